// File: doc/BRIEF.md
# Two-wire addressed memory slave engine

This block is the protocol engine for a slave on a two-wire serial bus that fronts a 256-byte storage space. It samples raw SCL and SDA on the system clock and detects START and STOP conditions. It shifts bytes in most significant bit first and recognises a device byte made of a fixed four-bit code, three strap pins and a direction bit. Acknowledge and read data go back on the bus through an open-drain pull-down enable. The engine itself never stretches the clock.

Written bytes leave through a valid/ready write-request port. The engine raises `wr_valid_o` with address and data and holds all three until `wr_ready_i` is seen high at a clock edge. The bus cannot be stalled. A data byte that completes while an earlier request is still waiting is therefore refused with a NACK and dropped. Reads use a synchronous port: a one-cycle `rd_en_o` pulse with `rd_addr_o`, and the byte is expected on `rd_data_i` in the next cycle. A downstream `busy_i` flag makes the engine refuse its device address, so a master can poll for the end of an internal write cycle. An address pointer outlives transactions, and it supports current-address, random and sequential reads as well as multi-byte writes.

Top module: `twowire_mem_slave`

## Requirements
- R1: A START seen at any point, including in the middle of a byte, restarts device-byte reception. A STOP seen at any point returns the engine to idle. Both release SDA, and a partly received data byte is never written.
- R2: The device byte is taken MSB first as code 1010, then strap bits 2..0, then R/W (1 = read). The engine acknowledges only an exact match. On a mismatch it sends no acknowledge and ignores the bus until the next START, issuing no write and no read.
- R3: If `busy_i` is high when the device byte completes, the engine does not acknowledge it. A later attempt with `busy_i` low is acknowledged.
- R4: In a write, the engine acknowledges the word-address byte and each data byte. Each data byte issues one request with the current pointer as address, and the pointer then steps by one, so several data bytes land at consecutive addresses.
- R5: A write request holds `wr_valid_o`, `wr_addr_o` and `wr_data_o` stable until `wr_ready_i` is high. A data byte that completes while a request is still waiting is not acknowledged and is discarded, and the rest of that transaction is ignored.
- R6: The pointer keeps the last accessed address plus one across transactions. It wraps from FFh to 00h for both reads and writes. It is 00h after reset. A read with no address phase returns the byte at the pointer.
- R7: A write of a word address followed by a repeated START and a read device byte returns the byte at that word address.
- R8: During a read, a master ACK (SDA low on the ninth clock) sends the byte at the next address. A master NACK ends the read with SDA released and no further read issued.
- R9: The acknowledge drive starts on the SCL falling edge after the eighth bit and ends on the next falling edge. Read data bits are driven MSB first and change only while SCL is low.
- R10: After a disturbed transfer, at most nine SCL pulses with the master releasing SDA leave SDA released, and the following START begins a normal transaction.
- R11: Each byte read from storage costs exactly one single-cycle `rd_en_o` pulse. `rd_addr_o` is valid in that cycle, and data is taken from `rd_data_i` one cycle later.
- R12: After reset, `sda_oe_o`, `wr_valid_o` and `rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull SDA low when high |
| strap_i | input | STRAP_W | Device select straps |
| busy_i | input | 1 | Downstream internal write cycle in progress |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_en_o | output | 1 | Read strobe, one cycle per byte |
| rd_addr_o | output | 8 | Read address, valid with rd_en_o |
| rd_data_i | input | 8 | Read data, one cycle after rd_en_o |

## Verification
The functions that can fall into the same cycle are the acceptance decision for a newly completed data byte and the write handshake of the byte before it, which is still waiting. The bench provokes this by holding `wr_ready_i` low across two data bytes. It then expects the second byte to be refused while the first request stays stable at the port. After `wr_ready_i` is released, a later read of the second address must return its old content. A second collision, a START or STOP arriving while the slave owns SDA or sits mid-byte, is provoked by cutting bytes short and by clocking through an unfinished read. It is judged by the release of SDA and by the next transaction behaving normally.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } twm_state_e;
endpackage

// File: rtl/twm_bus_sampler.sv
module twm_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/twm_addr_ptr.sv
module twm_addr_ptr import twm_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/twm_proto_fsm.sv
module twm_proto_fsm import twm_pkg::*; #(
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_CODE = 'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               wr_ready_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  output logic               sda_oe_o,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_en_o,
  output logic               ptr_load_o,
  output logic [ADDR_W-1:0]  ptr_val_o,
  output logic               ptr_inc_o
);
  twm_state_e        state, after_ack;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              ack_pend;
  logic              rd_q;
  logic [BYTE_W-1:0] byte_now;
  logic              dev_hit;

  assign byte_now = {rx_sr, sda_s};
  assign dev_hit  = (byte_now[BYTE_W-1:1] == {DEV_CODE, strap_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      after_ack  <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ack_pend   <= 1'b0;
      rd_q       <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rd_en_o    <= 1'b0;
      ptr_load_o <= 1'b0;
      ptr_val_o  <= '0;
      ptr_inc_o  <= 1'b0;
    end else begin
      rd_en_o    <= 1'b0;
      ptr_load_o <= 1'b0;
      ptr_inc_o  <= 1'b0;
      rd_q       <= rd_en_o;
      if (rd_q) tx_sr <= rd_data_i;
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;

      if (start_evt) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (scl_rise && state != ST_IDLE) begin
        if (bit_cnt < 4'd8) begin
          bit_cnt <= bit_cnt + 4'd1;
          if (state != ST_RDATA) begin
            rx_sr <= byte_now[BYTE_W-2:0];
            if (bit_cnt == 4'd7) begin
              case (state)
                ST_DEV: begin
                  if (dev_hit && !busy_i) begin
                    ack_pend <= 1'b1;
                    if (byte_now[0]) begin
                      after_ack <= ST_RDATA;
                      rd_en_o   <= 1'b1;
                      ptr_inc_o <= 1'b1;
                    end else begin
                      after_ack <= ST_ADDR;
                    end
                  end else begin
                    ack_pend  <= 1'b0;
                    after_ack <= ST_IDLE;
                  end
                end
                ST_ADDR: begin
                  ack_pend   <= 1'b1;
                  ptr_load_o <= 1'b1;
                  ptr_val_o  <= byte_now;
                  after_ack  <= ST_WDATA;
                end
                ST_WDATA: begin
                  if (!wr_valid_o || wr_ready_i) begin
                    wr_valid_o <= 1'b1;
                    wr_addr_o  <= ptr_i;
                    wr_data_o  <= byte_now;
                    ptr_inc_o  <= 1'b1;
                    ack_pend   <= 1'b1;
                    after_ack  <= ST_WDATA;
                  end else begin
                    ack_pend  <= 1'b0;
                    after_ack <= ST_IDLE;
                  end
                end
                default: begin
                  ack_pend  <= 1'b0;
                  after_ack <= ST_IDLE;
                end
              endcase
            end
          end
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          if (state == ST_RDATA) begin
            if (!sda_s) begin
              after_ack <= ST_RDATA;
              rd_en_o   <= 1'b1;
              ptr_inc_o <= 1'b1;
            end else begin
              after_ack <= ST_IDLE;
            end
          end
        end
      end else if (scl_fall && state != ST_IDLE) begin
        if (bit_cnt == 4'd8) begin
          sda_oe_o <= (state == ST_RDATA) ? 1'b0 : ack_pend;
        end else if (bit_cnt == 4'd9) begin
          bit_cnt  <= '0;
          state    <= after_ack;
          ack_pend <= 1'b0;
          sda_oe_o <= (after_ack == ST_RDATA) ? ~tx_sr[BYTE_W-1] : 1'b0;
        end else if (state == ST_RDATA && bit_cnt != 4'd0) begin
          sda_oe_o <= ~tx_sr[3'd7 - bit_cnt[2:0]];
        end
      end
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s); // R9
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe_o && state == ST_DEV); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o && state == ST_IDLE); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o); // R11
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE && !$past(scl_fall) |-> !sda_oe_o); // R2
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave import twm_pkg::*; #(
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_CODE = 'b1010,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_en_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0]  rd_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr_val, ptr;

  twm_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  twm_addr_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load), .load_val_i(ptr_val),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  twm_proto_fsm #(.STRAP_W(STRAP_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_i(strap_i), .busy_i(busy_i), .wr_ready_i(wr_ready_i),
    .rd_data_i(rd_data_i), .ptr_i(ptr),
    .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .rd_en_o(rd_en_o),
    .ptr_load_o(ptr_load), .ptr_val_o(ptr_val), .ptr_inc_o(ptr_inc)
  );

  assign rd_addr_o = ptr;

  AST_RD_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> rd_addr_o == $past(rd_addr_o) + 8'd1); // R6
endmodule

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0, wr_ready = 1'b1;
  logic sda_oe, wr_valid, rd_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_line;
  logic [7:0] dmem [256];
  logic [7:0] emem [256];
  logic [15:0] exp_q [$];
  logic [7:0] bptr;
  int tests = 0, fails = 0, rd_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  twowire_mem_slave u_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_en_o(rd_en),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) if (rd_en) rd_data <= dmem[rd_addr];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write monitor: pops the scoreboard on each accepted request
  always @(negedge clk) begin
    if (rst_n && rd_en) rd_cnt++;
    if (rst_n && wr_valid && wr_ready) begin
      dmem[wr_addr] = wr_data;
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          fails++;
          $display("FAIL R4 write actual=%0h expected=%0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wq(); m_scl = 1'b1; wq(); r = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input bit rel_chk, input string tag);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    chk(tag, !r, exp_ack);
    if (rel_chk) chk("R9 release after ack", sda_oe, 0);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clk_bit(!mack, r);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic xfer_write(input logic [7:0] a, input logic [7:0] d0, input int n);
    bus_start();
    send_byte(dev(1'b0), 1'b1, 1'b1, "R2 dev ack");
    send_byte(a, 1'b1, 1'b1, "R4 addr ack");
    for (int i = 0; i < n; i++) begin
      logic [7:0] ad, dd;
      ad = a + 8'(i);
      dd = d0 + 8'(i);
      exp_q.push_back({ad, dd});
      emem[ad] = dd;
      send_byte(dd, 1'b1, 1'b1, "R4 data ack");
    end
    bus_stop();
    bptr = a + 8'(n);
    wq(); wq();
  endtask

  task automatic set_addr(input logic [7:0] a);
    bus_start();
    send_byte(dev(1'b0), 1'b1, 1'b1, "R7 dev ack");
    send_byte(a, 1'b1, 1'b1, "R7 addr ack");
    bptr = a;
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] d;
    bus_start();
    send_byte(dev(1'b1), 1'b1, 1'b0, "R6 read dev ack");
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(tag, d, emem[bptr]);
      bptr = bptr + 8'd1;
    end
    chk("R8 release after nack", sda_oe, 0);
    bus_stop();
    wq();
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic r;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'((i * 37 + 11) & 255);
      emem[i] = 8'((i * 37 + 11) & 255);
    end
    bptr = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();
    chk("R12 sda_oe reset", sda_oe, 0);
    chk("R12 wr_valid reset", wr_valid, 0);
    chk("R12 rd_en reset", rd_en, 0);

    // R6/R12: pointer starts at 00
    read_seq(1, "R6 current read after reset");

    // R2: wrong strap and wrong code are ignored
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, 1'b0, 1'b1, "R2 strap mismatch nack");
    send_byte(8'h30, 1'b0, 1'b1, "R2 ignored byte");
    send_byte(8'h99, 1'b0, 1'b1, "R2 ignored byte");
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, 1'b0, 1'b1, "R2 code mismatch nack");
    bus_stop();
    read_seq(1, "R2 pointer untouched by ignored access");

    // R4: byte write and multi-byte write
    xfer_write(8'h10, 8'hC3, 1);
    xfer_write(8'h20, 8'h61, 4);

    // R7/R8/R11: random then sequential read
    set_addr(8'h21);
    c0 = rd_cnt;
    read_seq(3, "R7 R8 random sequential read");
    chk("R11 one strobe per byte", rd_cnt - c0, 3);
    read_seq(1, "R6 current read continues");

    // R6: wrap for writes and reads
    xfer_write(8'hFE, 8'hA1, 3);
    set_addr(8'hFE);
    read_seq(3, "R6 read wraps FF to 00");
    read_seq(1, "R6 current read after wrap");

    // R3: busy refuses the device byte
    #1 busy = 1'b1;
    bus_start();
    send_byte(dev(1'b0), 1'b0, 1'b1, "R3 busy nack");
    bus_stop();
    busy = 1'b0;
    xfer_write(8'h30, 8'h5C, 1);

    // R5: back-pressure collision
    wr_ready = 1'b0;
    bus_start();
    send_byte(dev(1'b0), 1'b1, 1'b1, "R5 dev ack");
    send_byte(8'h40, 1'b1, 1'b1, "R5 addr ack");
    exp_q.push_back({8'h40, 8'h11});
    emem[8'h40] = 8'h11;
    send_byte(8'h11, 1'b1, 1'b1, "R5 first data ack");
    send_byte(8'h22, 1'b0, 1'b1, "R5 second data nack");
    bus_stop();
    chk("R5 valid held", wr_valid, 1);
    chk("R5 addr held", wr_addr, 8'h40);
    chk("R5 data held", wr_data, 8'h11);
    wr_ready = 1'b1;
    wq();
    chk("R5 valid drops after accept", wr_valid, 0);
    bptr = 8'h41;
    read_seq(1, "R5 refused byte discarded");

    // R1: START in the middle of a data byte
    set_addr(8'h50);
    for (int i = 0; i < 4; i++) clk_bit(i[0], r);
    read_seq(1, "R1 mid-byte start aborts write");
    // R1: STOP in the middle of a byte
    bus_start();
    send_byte(dev(1'b0), 1'b1, 1'b1, "R1 dev ack");
    for (int i = 0; i < 3; i++) clk_bit(1'b0, r);
    bus_stop();
    chk("R1 stop releases", sda_oe, 0);
    xfer_write(8'h58, 8'h0F, 2);

    // R10: recovery from an unfinished read with slave holding SDA
    xfer_write(8'h60, 8'h00, 1);
    set_addr(8'h60);
    bus_start();
    send_byte(dev(1'b1), 1'b1, 1'b0, "R10 read dev ack");
    for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
    chk("R10 slave driving zero bit", sda_oe, 1);
    for (int i = 0; i < 9; i++) clk_bit(1'b1, r);
    chk("R10 released after nine clocks", sda_oe, 0);
    xfer_write(8'h70, 8'hE4, 2);
    set_addr(8'h70);
    read_seq(2, "R10 normal after recovery");

    wq(); wq();
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule